// File: doc/BRIEF.md
# Sparse Coherence Directory Slice

This block keeps coherence bookkeeping for a small chip multiprocessor whose cores each own a private cache. Every block held in any private cache has at least one directory entry. Each entry holds a state and up to two core identifiers. A core consults the directory only when it cannot finish an access locally: a read miss, a write miss, or a write to a line it holds shared. For each request the directory returns one of four answers: a shared grant, an exclusive grant, a forward to the core that currently owns the line, or a retry. When other copies must disappear, it sends invalidations to those cores and counts their acknowledgements.

The store is set-associative and has nothing behind it. When a new address has to be placed in a set whose ways are all in use, a victim entry is pushed out. Every core that entry listed is invalidated, and the requester is told to retry. Sharers are held as a short list of core numbers rather than a presence vector. A widely shared line therefore spreads over several entries with the same tag, and each lookup merges the hits from all of them. Entries in the middle of an invalidation round are marked pending. Requests to a pending address are bounced with a retry until the round completes.

Top module: `coh_dir_slice`

## Requirements
- R1: While reset is held and right after it is released, `req_ready` is 1, `resp_valid` is 0 and `inv_valid` is 0.
- R2: A request that misses, when its set has an unused way, is answered in the cycle after acceptance. The answer has `resp_kind` 1 (exclusive grant), `resp_core` equal to the requester and `resp_addr` equal to the request address. This holds for reads and for writes.
- R3: A read from a core that does not hold a line owned exclusively by another core is answered with `resp_kind` 2 (forward), with `resp_core` naming the owner. Afterwards both cores are recorded as sharers.
- R4: A read from a core that is not yet listed for a shared line is answered with `resp_kind` 0 (shared grant). The requester goes into a free pointer slot of a matching entry. If every matching entry is full, it goes into a new entry with the same tag in an unused way.
- R5: A request from a core that already holds the line changes no holders. A read gets `resp_kind` 0 if the line is shared and 1 if it is exclusive. A write from the sole holder gets `resp_kind` 1 at once, with no invalidation.
- R6: A write to a line with other holders sends one invalidation per other holder, lowest core number first, each carrying the line address. The exclusive grant (`resp_kind` 1) follows only after every acknowledgement has arrived. After that grant, all duplicate entries for the address are gone and the writer is the single owner.
- R7: While an address is pending, every request to it receives `resp_kind` 3 (retry). Requests to other addresses that need no invalidation are served in the normal way during that time. `req_ready` is low only in the cycle an invalidation round completes.
- R8: When a miss, or a new sharer entry, meets a set in which every way is in use, a victim is chosen and its holders are invalidated. The requester receives `resp_kind` 3. Once the acknowledgements are in, the freed way can be allocated.
- R9: The victim is the lowest-numbered way whose recently-used bit is clear. Allocation and hits set the bit of the way they touch. When that would leave every bit set, only the touched way's bit is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | ADDR_W | Block address; low bits select the set |
| req_core | input | log2(NUM_CORES) | Requesting core |
| req_write | input | 1 | 1 = write (ownership), 0 = read |
| resp_valid | output | 1 | Response pulse |
| resp_kind | output | 2 | 0 shared grant, 1 exclusive grant, 2 forward, 3 retry |
| resp_core | output | log2(NUM_CORES) | Requester for grants and retries, owner for forwards |
| resp_addr | output | ADDR_W | Address the response refers to |
| inv_valid | output | 1 | Invalidation pulse |
| inv_core | output | log2(NUM_CORES) | Core to invalidate |
| inv_addr | output | ADDR_W | Block address to invalidate |
| inv_ack_valid | input | 1 | One acknowledgement for an earlier invalidation |

## Verification
The assertions assume that the caches send exactly one acknowledgement for each invalidation. They also assume that an acknowledgement never arrives while the directory has nothing outstanding. The cache model meets both conditions by feeding every observed invalidation pulse through a fixed-length delay line, which produces one acknowledgement per pulse. The stimulus keeps requests from a core consistent with what that core holds, so the requester never appears among the holders it is asked to invalidate. Requests are held steady until they are accepted.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

   typedef enum logic [1:0] {
      ST_INV = 2'd0,
      ST_SHR = 2'd1,
      ST_EXC = 2'd2,
      ST_PND = 2'd3
   } dir_state_e;

   typedef enum logic [1:0] {
      RSP_GNT_S = 2'd0,
      RSP_GNT_E = 2'd1,
      RSP_FWD   = 2'd2,
      RSP_RETRY = 2'd3
   } rsp_kind_e;

   typedef enum logic [3:0] {
      ACT_NONE,
      ACT_ALLOC_E,
      ACT_ALLOC_S,
      ACT_TOUCH,
      ACT_FWD,
      ACT_ADD,
      ACT_COLLAPSE,
      ACT_UPG,
      ACT_EVICT
   } dir_act_e;

endpackage

// File: rtl/coh_dir_pick.sv
module coh_dir_pick #(
   parameter int N = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = |req;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/coh_dir_inv_engine.sv
module coh_dir_inv_engine #(
   parameter int NUM_CORES = 8,
   parameter int ADDR_W    = 12,
   localparam int CORE_W   = $clog2(NUM_CORES),
   localparam int CNT_W    = $clog2(NUM_CORES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [NUM_CORES-1:0] load_mask,
   input  logic [ADDR_W-1:0]    load_addr,
   input  logic                 ack_valid,
   output logic                 busy,
   output logic                 done,
   output logic [CNT_W-1:0]     outst,
   output logic                 inv_valid,
   output logic [CORE_W-1:0]    inv_core,
   output logic [ADDR_W-1:0]    inv_addr
);
   logic [NUM_CORES-1:0] send_q;
   logic                 any_left;

   coh_dir_pick #(.N(NUM_CORES)) u_next (
      .req(send_q), .found(any_left), .idx(inv_core)
   );

   assign inv_valid = busy && any_left;
   assign done      = busy && !any_left && (outst == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         send_q   <= '0;
         outst    <= '0;
         inv_addr <= '0;
      end else if (load && !busy) begin
         busy     <= 1'b1;
         send_q   <= load_mask;
         outst    <= '0;
         inv_addr <= load_addr;
      end else if (busy) begin
         if (inv_valid) send_q[inv_core] <= 1'b0;
         outst <= outst + CNT_W'(inv_valid) - CNT_W'(ack_valid);
         if (done) busy <= 1'b0;
      end
   end
endmodule

// File: rtl/coh_dir_slice.sv
module coh_dir_slice
   import coh_dir_pkg::*;
#(
   parameter int NUM_CORES = 8,
   parameter int WAYS      = 8,
   parameter int SETS      = 4,
   parameter int PTRS      = 2,
   parameter int ADDR_W    = 12,
   localparam int CORE_W   = $clog2(NUM_CORES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [CORE_W-1:0] req_core,
   input  logic              req_write,
   output logic              resp_valid,
   output logic [1:0]        resp_kind,
   output logic [CORE_W-1:0] resp_core,
   output logic [ADDR_W-1:0] resp_addr,
   output logic              inv_valid,
   output logic [CORE_W-1:0] inv_core,
   output logic [ADDR_W-1:0] inv_addr,
   input  logic              inv_ack_valid
);
   localparam int SET_W  = $clog2(SETS);
   localparam int TAG_W  = ADDR_W - SET_W;
   localparam int WAY_W  = $clog2(WAYS);
   localparam int SLOT_W = (PTRS > 1) ? $clog2(PTRS) : 1;
   localparam int CNT_W  = $clog2(NUM_CORES + 1);

   if (NUM_CORES < 2 || (NUM_CORES & (NUM_CORES - 1)) != 0) begin : g_bad_cores
      $error("NUM_CORES must be a power of two, at least 2");
   end
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two, at least 2");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if (PTRS < 2) begin : g_bad_ptrs
      $error("PTRS must be at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the set index width");
   end

   // ---------------- storage ----------------
   dir_state_e        st_q  [SETS][WAYS];
   logic [TAG_W-1:0]  tag_q [SETS][WAYS];
   logic [PTRS-1:0]   pv_q  [SETS][WAYS];
   logic [CORE_W-1:0] pc_q  [SETS][WAYS][PTRS];
   logic [WAYS-1:0]   mru_q [SETS];

   // ---------------- lookup ----------------
   logic [SET_W-1:0] rs;
   logic [TAG_W-1:0] rt;
   assign rs = req_addr[SET_W-1:0];
   assign rt = req_addr[ADDR_W-1:SET_W];

   logic [WAYS-1:0] match, free_v, pend_v, excl_v, slot_v;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign match[w]  = (st_q[rs][w] != ST_INV) && (tag_q[rs][w] == rt);
      assign free_v[w] = (st_q[rs][w] == ST_INV);
      assign pend_v[w] = (st_q[rs][w] == ST_PND);
      assign excl_v[w] = match[w] && (st_q[rs][w] == ST_EXC);
      assign slot_v[w] = match[w] && (st_q[rs][w] == ST_SHR) && !(&pv_q[rs][w]);
   end

   logic hit, pend_any, excl_any;
   assign hit      = |match;
   assign pend_any = |(match & pend_v);
   assign excl_any = |excl_v;

   logic             home_found, free_found, slot_found, vic_lru_found, vic_found;
   logic [WAY_W-1:0] home_way, free_way, slot_way, vic_lru_way, vic_any_way, vic_way;
   logic             slot_idx_found;
   logic [SLOT_W-1:0] slot_idx;

   coh_dir_pick #(.N(WAYS)) u_home (.req(match),  .found(home_found), .idx(home_way));
   coh_dir_pick #(.N(WAYS)) u_free (.req(free_v), .found(free_found), .idx(free_way));
   coh_dir_pick #(.N(WAYS)) u_slotw(.req(slot_v), .found(slot_found), .idx(slot_way));
   coh_dir_pick #(.N(PTRS)) u_sloti(.req(~pv_q[rs][slot_way]), .found(slot_idx_found), .idx(slot_idx));
   coh_dir_pick #(.N(WAYS)) u_vlru (.req(~pend_v & ~mru_q[rs]), .found(vic_lru_found), .idx(vic_lru_way));
   coh_dir_pick #(.N(WAYS)) u_vany (.req(~pend_v), .found(vic_found), .idx(vic_any_way));
   assign vic_way = vic_lru_found ? vic_lru_way : vic_any_way;

   logic [NUM_CORES-1:0] holders, others, vic_mask;
   logic [CORE_W-1:0]    owner;
   assign owner = pc_q[rs][home_way][0];

   always_comb begin
      holders  = '0;
      vic_mask = '0;
      for (int w = 0; w < WAYS; w++) begin
         for (int p = 0; p < PTRS; p++) begin
            if (match[w] && pv_q[rs][w][p]) holders[pc_q[rs][w][p]] = 1'b1;
         end
      end
      for (int p = 0; p < PTRS; p++) begin
         if (pv_q[rs][vic_way][p]) vic_mask[pc_q[rs][vic_way][p]] = 1'b1;
      end
   end
   assign others = holders & ~(NUM_CORES'(1) << req_core);

   // ---------------- decision ----------------
   dir_act_e          act;
   rsp_kind_e         r_kind;
   logic [CORE_W-1:0] r_core;
   logic              r_give;
   logic              eng_busy, eng_done;
   logic [CNT_W-1:0]  outst;

   always_comb begin
      act    = ACT_NONE;
      r_kind = RSP_RETRY;
      r_core = req_core;
      r_give = 1'b1;
      if (pend_any) begin
         act = ACT_NONE;
      end else if (!hit) begin
         if (free_found) begin
            act    = ACT_ALLOC_E;
            r_kind = RSP_GNT_E;
         end else if (!eng_busy && vic_found) begin
            act = ACT_EVICT;
         end
      end else if (!req_write) begin
         if (holders[req_core]) begin
            act    = ACT_TOUCH;
            r_kind = excl_any ? RSP_GNT_E : RSP_GNT_S;
         end else if (excl_any) begin
            act    = ACT_FWD;
            r_kind = RSP_FWD;
            r_core = owner;
         end else if (slot_found && slot_idx_found) begin
            act    = ACT_ADD;
            r_kind = RSP_GNT_S;
         end else if (free_found) begin
            act    = ACT_ALLOC_S;
            r_kind = RSP_GNT_S;
         end else if (!eng_busy && vic_found) begin
            act = ACT_EVICT;
         end
      end else begin
         if (others == '0) begin
            act    = ACT_COLLAPSE;
            r_kind = RSP_GNT_E;
         end else if (!eng_busy) begin
            act    = ACT_UPG;
            r_give = 1'b0;
         end
      end
   end

   logic req_fire;
   assign req_ready = !eng_done;
   assign req_fire  = req_valid && req_ready;

   // ---------------- invalidation engine ----------------
   logic                 eng_load;
   logic [NUM_CORES-1:0] eng_mask;
   logic [ADDR_W-1:0]    eng_addr;
   assign eng_load = req_fire && (act == ACT_UPG || act == ACT_EVICT);
   assign eng_mask = (act == ACT_UPG) ? others : vic_mask;
   assign eng_addr = (act == ACT_UPG) ? req_addr : {tag_q[rs][vic_way], rs};

   coh_dir_inv_engine #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .load(eng_load), .load_mask(eng_mask),
      .load_addr(eng_addr), .ack_valid(inv_ack_valid), .busy(eng_busy),
      .done(eng_done), .outst(outst), .inv_valid(inv_valid),
      .inv_core(inv_core), .inv_addr(inv_addr)
   );

   // ---------------- update ----------------
   function automatic logic [WAYS-1:0] mru_touch(input logic [WAYS-1:0] m,
                                                  input logic [WAY_W-1:0] w);
      logic [WAYS-1:0] n;
      n = m | (WAYS'(1) << w);
      if (&n) n = WAYS'(1) << w;
      return n;
   endfunction

   logic [SET_W-1:0]  fin_set;
   logic [TAG_W-1:0]  fin_tag;
   logic [WAY_W-1:0]  fin_way;
   logic [CORE_W-1:0] fin_core;
   logic              fin_evict;
   logic              resp_valid_q;
   logic [1:0]        resp_kind_q;
   logic [CORE_W-1:0] resp_core_q;
   logic [ADDR_W-1:0] resp_addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            mru_q[s] <= '0;
            for (int w = 0; w < WAYS; w++) begin
               st_q[s][w]  <= ST_INV;
               tag_q[s][w] <= '0;
               pv_q[s][w]  <= '0;
               for (int p = 0; p < PTRS; p++) pc_q[s][w][p] <= '0;
            end
         end
         fin_set      <= '0;
         fin_tag      <= '0;
         fin_way      <= '0;
         fin_core     <= '0;
         fin_evict    <= 1'b0;
         resp_valid_q <= 1'b0;
         resp_kind_q  <= '0;
         resp_core_q  <= '0;
         resp_addr_q  <= '0;
      end else begin
         resp_valid_q <= 1'b0;
         if (req_fire) begin
            resp_valid_q <= r_give;
            resp_kind_q  <= r_kind;
            resp_core_q  <= r_core;
            resp_addr_q  <= req_addr;
            case (act)
               ACT_ALLOC_E, ACT_ALLOC_S: begin
                  st_q[rs][free_way]     <= (act == ACT_ALLOC_E) ? ST_EXC : ST_SHR;
                  tag_q[rs][free_way]    <= rt;
                  pv_q[rs][free_way]     <= PTRS'(1);
                  pc_q[rs][free_way][0]  <= req_core;
                  mru_q[rs]              <= mru_touch(mru_q[rs], free_way);
               end
               ACT_TOUCH: mru_q[rs] <= mru_touch(mru_q[rs], home_way);
               ACT_FWD: begin
                  st_q[rs][home_way]    <= ST_SHR;
                  pv_q[rs][home_way]    <= PTRS'(3);
                  pc_q[rs][home_way][1] <= req_core;
                  mru_q[rs]             <= mru_touch(mru_q[rs], home_way);
               end
               ACT_ADD: begin
                  pv_q[rs][slot_way][slot_idx] <= 1'b1;
                  pc_q[rs][slot_way][slot_idx] <= req_core;
                  mru_q[rs]                    <= mru_touch(mru_q[rs], slot_way);
               end
               ACT_COLLAPSE: begin
                  for (int w = 0; w < WAYS; w++) begin
                     if (match[w] && WAY_W'(w) != home_way) st_q[rs][w] <= ST_INV;
                  end
                  st_q[rs][home_way]    <= ST_EXC;
                  pv_q[rs][home_way]    <= PTRS'(1);
                  pc_q[rs][home_way][0] <= req_core;
                  mru_q[rs]             <= mru_touch(mru_q[rs], home_way);
               end
               ACT_UPG: begin
                  st_q[rs][home_way] <= ST_PND;
                  fin_set   <= rs;
                  fin_tag   <= rt;
                  fin_way   <= home_way;
                  fin_core  <= req_core;
                  fin_evict <= 1'b0;
               end
               ACT_EVICT: begin
                  st_q[rs][vic_way] <= ST_PND;
                  fin_set   <= rs;
                  fin_tag   <= tag_q[rs][vic_way];
                  fin_way   <= vic_way;
                  fin_core  <= req_core;
                  fin_evict <= 1'b1;
               end
               default: ;
            endcase
         end else if (eng_done) begin
            if (fin_evict) begin
               st_q[fin_set][fin_way] <= ST_INV;
            end else begin
               for (int w = 0; w < WAYS; w++) begin
                  if (WAY_W'(w) != fin_way && st_q[fin_set][w] != ST_INV &&
                      tag_q[fin_set][w] == fin_tag) st_q[fin_set][w] <= ST_INV;
               end
               st_q[fin_set][fin_way]    <= ST_EXC;
               pv_q[fin_set][fin_way]    <= PTRS'(1);
               pc_q[fin_set][fin_way][0] <= fin_core;
               mru_q[fin_set]            <= mru_touch(mru_q[fin_set], fin_way);
               resp_valid_q <= 1'b1;
               resp_kind_q  <= RSP_GNT_E;
               resp_core_q  <= fin_core;
               resp_addr_q  <= {fin_tag, fin_set};
            end
         end
      end
   end

   assign resp_valid = resp_valid_q;
   assign resp_kind  = resp_kind_q;
   assign resp_core  = resp_core_q;
   assign resp_addr  = resp_addr_q;

endmodule

// File: rtl/coh_dir_slice_sva.sv
module coh_dir_slice_sva #(
   parameter int NUM_CORES = 8,
   localparam int CORE_W   = $clog2(NUM_CORES),
   localparam int CNT_W    = $clog2(NUM_CORES + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [CORE_W-1:0] req_core,
   input logic              resp_valid,
   input logic [1:0]        resp_kind,
   input logic [CORE_W-1:0] resp_core,
   input logic              inv_valid,
   input logic              inv_ack_valid,
   input logic              eng_busy,
   input logic              eng_done,
   input logic              pend_any,
   input logic [CNT_W-1:0]  outst
);
   AST_RESP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> ($past(req_valid && req_ready) || $past(eng_done))); // R2

   AST_FWD_NOT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=>
         !(resp_valid && resp_kind == 2'd2 && resp_core == $past(req_core))); // R3

   AST_ACK_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
      inv_ack_valid |-> (outst != '0 || inv_valid)); // R6

   AST_PENDING_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && pend_any) |=> (resp_valid && resp_kind == 2'd3)); // R7

   AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_busy |-> req_ready); // R7
endmodule

bind coh_dir_slice coh_dir_slice_sva #(.NUM_CORES(NUM_CORES)) sva_i (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_core(req_core), .resp_valid(resp_valid), .resp_kind(resp_kind),
   .resp_core(resp_core), .inv_valid(inv_valid), .inv_ack_valid(inv_ack_valid),
   .eng_busy(eng_busy), .eng_done(eng_done), .pend_any(pend_any), .outst(outst)
);

// File: tb/coh_dir_slice_tb_top.sv
module coh_dir_slice_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int ACK_LAT    = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [11:0] req_addr = '0;
   logic [2:0]  req_core = '0;
   logic        req_write = 1'b0;
   logic        resp_valid;
   logic [1:0]  resp_kind;
   logic [2:0]  resp_core;
   logic [11:0] resp_addr;
   logic        inv_valid;
   logic [2:0]  inv_core;
   logic [11:0] inv_addr;
   logic        inv_ack_valid;
   logic [ACK_LAT-1:0] ack_pipe = '0;

   int n_checks = 0;
   int n_fail   = 0;

   int    q_kind[$];
   int    q_core[$];
   int    q_addr[$];
   string q_tag[$];
   int    q_icore[$];
   int    q_iaddr[$];
   string q_itag[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   coh_dir_slice dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_core(req_core), .req_write(req_write),
      .resp_valid(resp_valid), .resp_kind(resp_kind), .resp_core(resp_core),
      .resp_addr(resp_addr), .inv_valid(inv_valid), .inv_core(inv_core),
      .inv_addr(inv_addr), .inv_ack_valid(inv_ack_valid)
   );

   // cache model: one acknowledgement per invalidation, ACK_LAT cycles later
   assign inv_ack_valid = ack_pipe[ACK_LAT-1];
   always @(negedge clk) begin
      if (!rst_n) ack_pipe <= '0;
      else        ack_pipe <= {ack_pipe[ACK_LAT-2:0], inv_valid};
   end

   task automatic check(input bit ok, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic exp_rsp(input int k, input int c, input int a, input string tag);
      q_kind.push_back(k); q_core.push_back(c); q_addr.push_back(a); q_tag.push_back(tag);
   endtask

   task automatic exp_inv(input int c, input int a, input string tag);
      q_icore.push_back(c); q_iaddr.push_back(a); q_itag.push_back(tag);
   endtask

   task automatic issue(input int a, input int c, input bit w);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = 12'(a);
      req_core  = 3'(c);
      req_write = w;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic send(input int a, input int c, input bit w, input int k,
                       input int ec, input string tag);
      exp_rsp(k, ec, a, tag);
      issue(a, c, w);
   endtask

   task automatic drain();
      while (q_kind.size() != 0 || q_icore.size() != 0) @(negedge clk);
      repeat (ACK_LAT + 4) @(negedge clk);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (resp_valid) begin
            if (q_kind.size() == 0) begin
               check(1'b0, "unexpected response", int'(resp_kind), -1);
            end else begin
               int k, c, a;
               string t;
               k = q_kind.pop_front(); c = q_core.pop_front();
               a = q_addr.pop_front(); t = q_tag.pop_front();
               n_checks++;
               if (int'(resp_kind) != k || int'(resp_core) != c || int'(resp_addr) != a) begin
                  n_fail++;
                  $display("FAIL %s: kind=%0d core=%0d addr=%h expected kind=%0d core=%0d addr=%h",
                           t, resp_kind, resp_core, resp_addr, k, c, a);
               end
            end
         end
         if (inv_valid) begin
            if (q_icore.size() == 0) begin
               check(1'b0, "unexpected invalidation", int'(inv_core), -1);
            end else begin
               int c, a;
               string t;
               c = q_icore.pop_front(); a = q_iaddr.pop_front(); t = q_itag.pop_front();
               n_checks++;
               if (int'(inv_core) != c || int'(inv_addr) != a) begin
                  n_fail++;
                  $display("FAIL %s: inv core=%0d addr=%h expected core=%0d addr=%h",
                           t, inv_core, inv_addr, c, a);
               end
            end
         end
      end
   end

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
      check(resp_valid == 1'b0, "R1 no response after reset", int'(resp_valid), 0);
      check(inv_valid == 1'b0, "R1 no invalidation after reset", int'(inv_valid), 0);

      // R2: misses into free ways
      send('h010, 1, 1'b0, 1, 1, "R2 read miss");
      send('h0A3, 6, 1'b1, 1, 6, "R2 write miss");
      // R3: forward to owner
      send('h010, 2, 1'b0, 2, 1, "R3 forward to owner");
      // R4: duplicate entry, then free slot in it
      send('h010, 3, 1'b0, 0, 3, "R4 duplicate entry");
      send('h010, 4, 1'b0, 0, 4, "R4 free slot");
      // R5: existing sharer reads
      send('h010, 2, 1'b0, 0, 2, "R5 sharer reread");
      drain();

      // R6: upgrade with three other sharers
      exp_inv(1, 'h010, "R6 inv core1");
      exp_inv(3, 'h010, "R6 inv core3");
      exp_inv(4, 'h010, "R6 inv core4");
      exp_rsp(1, 2, 'h010, "R6 grant after acks");
      issue('h010, 2, 1'b1);
      drain();
      send('h010, 5, 1'b0, 2, 2, "R6 single owner after upgrade");
      drain();

      // R7: pending address retried, other address served
      exp_inv(2, 'h010, "R7 inv core2");
      issue('h010, 5, 1'b1);
      send('h010, 6, 1'b0, 3, 6, "R7 retry pending");
      send('h020, 4, 1'b0, 1, 4, "R7 other address served");
      exp_rsp(1, 5, 'h010, "R7 grant after round");
      drain();

      // R5: sole holder write and reread
      send('h020, 4, 1'b1, 1, 4, "R5 sole holder write");
      send('h020, 4, 1'b0, 1, 4, "R5 owner reread");
      drain();

      // R8/R9: fill set 1, then evict
      for (int k = 1; k <= 8; k++) send((k << 4) | 1, 0, 1'b0, 1, 0, "R8 fill set");
      drain();
      exp_inv(0, 'h011, "R9 victim way0");
      send('h901, 7, 1'b0, 3, 7, "R8 retry on full set");
      drain();
      send('h901, 7, 1'b0, 1, 7, "R8 freed way allocated");
      exp_inv(0, 'h021, "R9 victim way1");
      send('h011, 3, 1'b0, 3, 3, "R8 second eviction");
      send('h021, 5, 1'b0, 3, 5, "R7 retry evicting address");
      drain();
      send('h011, 3, 1'b0, 1, 3, "R8 allocate after eviction");
      drain();

      check(q_kind.size() == 0, "R2 leftover responses", q_kind.size(), 0);
      check(q_icore.size() == 0, "R6 leftover invalidations", q_icore.size(), 0);
      finish_run();
   end
endmodule